// File: doc/BRIEF.md
# Write-Cycle Bus Sequencer

This block carries write transactions from a processor core onto an external system bus. The bus carries either 64 or 32 bits of data per beat. The core hands over one request at a time: a byte address, a 256-bit payload, and two flags. The block flag asks for a full 32-byte cache-line write. The doubleword flag marks a single 8-byte transfer. The sequencer puts the address on the bus for one cycle. It then waits a programmable number of idle bus cycles, from 0 to 7. After that it issues the data beats in ascending address order. Each beat is held until the bus signals ready.

Two settings are fixed for the whole run, and both are captured while reset is held:
- the gap length;
- the bus width.

A gap of zero gives the classic timing, in which the first data beat follows the address cycle directly. Systems that drive synchronous DRAM over discrete logic can use the gap to give the memory time after the address. On a 32-bit bus, line writes take eight word beats and doubleword writes are split into two word beats.

Top module: `wbc_write_ctrl`

## Requirements
- R1: `mode_dly` (3-bit gap count) and `mode_wide` (1 = 64-bit bus, 0 = 32-bit bus) are captured only while reset is held. Changes on these inputs after reset is released have no effect on gap length or beat layout.
- R2: Each accepted request produces exactly one address cycle (`bus_addr_valid` high for one clock) in the cycle after acceptance. `bus_addr` then equals the base address. The base address is:
  - for a line write, the request address with bits [4:0] cleared;
  - for a doubleword write, the request address with bits [2:0] cleared;
  - for any other write, the request address unchanged.
- R3: With a captured gap of 0, the first data beat is valid in the clock right after the address cycle.
- R4: With a captured gap of D (1..7), exactly D clocks with neither address nor data valid lie between the address cycle and the first data beat. This holds for line writes and single writes alike.
- R5: A line write issues 4 beats on a 64-bit bus and 8 beats on a 32-bit bus. Beat addresses start at the line base and ascend in steps of 8 (64-bit bus) or 4 (32-bit bus).
- R6: A single write issues one beat, except a doubleword write on a 32-bit bus. That write issues two beats: first at the 8-aligned address, then at that address plus 4.
- R7: On a 64-bit bus, beat i carries `req_data[64i+63:64i]`. On a 32-bit bus, beat i carries `req_data[32i+31:32i]` in `bus_data[31:0]`, and `bus_data[63:32]` reads zero.
- R8: A data beat completes only on a clock where `bus_ready` is high. Until then, `bus_data_valid`, `bus_data` and `bus_addr` hold steady.
- R9: `req_ready` is high only when the bus is idle. `busy` rises in the address cycle and stays high until the clock after the final beat completes. A request presented while busy is not taken.
- R10: While reset is held, `busy`, `bus_addr_valid` and `bus_data_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| mode_dly | input | 3 | Gap count, captured during reset |
| mode_wide | input | 1 | Bus width select, captured during reset (1 = 64-bit) |
| req_valid | input | 1 | Core presents a write request |
| req_ready | output | 1 | Sequencer idle, request taken this clock |
| req_block | input | 1 | Request is a full line write |
| req_dword | input | 1 | Single request is 8 bytes wide |
| req_addr | input | 32 | Byte address of the request |
| req_data | input | 256 | Write payload; low 64 bits for single writes |
| busy | output | 1 | Transaction in progress |
| bus_addr_valid | output | 1 | Address cycle on the bus |
| bus_addr | output | 32 | Address for the address cycle or the current beat |
| bus_data_valid | output | 1 | Data beat on the bus |
| bus_data | output | 64 | Beat data |
| bus_ready | input | 1 | Bus accepts the current beat |

## Verification
The hardest case to reach is a gap setting that differs from what the mode pins show once reset has been released. This case proves the value was captured and is not read live. The bench resets under many gap and width pairs and then drives the mode pins to random values before sending any request. A second hard case is the narrow-bus doubleword split with the ready line stalling between its two halves. Random ready throttling on every beat, combined with directed single-doubleword requests on the 32-bit setting, produces it.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_GAP  = 2'd2,
    ST_DATA = 2'd3
  } wbc_state_e;
endpackage

// File: rtl/wbc_rst_sync.sv
module wbc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_n_o = s2_q;
endmodule

// File: rtl/wbc_cfg_latch.sv
module wbc_cfg_latch #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] mode_dly,
  input  logic             mode_wide,
  output logic [DLY_W-1:0] cfg_dly,
  output logic             cfg_wide
);
  // Loads only while reset is held; frozen once reset is released.
  logic cap_en;
  assign cap_en = ~rst_n;

  always_ff @(posedge clk) begin
    if (cap_en) begin
      cfg_dly  <= mode_dly;
      cfg_wide <= mode_wide;
    end
  end
endmodule

// File: rtl/wbc_gap_timer.sv
module wbc_gap_timer #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             dec,
  input  logic [DLY_W-1:0] load_val,
  output logic             last
);
  logic [DLY_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = load_val;
    else if (dec) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == DLY_W'(1));
endmodule

// File: rtl/wbc_beat_sel.sv
module wbc_beat_sel #(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int LINE_DW = 4,
  parameter int BW      = 3
) (
  input  logic [DW*LINE_DW-1:0] payload,
  input  logic [AW-1:0]         base,
  input  logic [BW-1:0]         idx,
  input  logic                  wide,
  output logic [AW-1:0]         beat_addr,
  output logic [DW-1:0]         beat_data
);
  localparam int HW    = DW / 2;
  localparam int NWORD = 2 * LINE_DW;
  localparam int WSH   = $clog2(DW / 8);
  localparam int NSH   = WSH - 1;
  localparam int DIW   = $clog2(LINE_DW);

  logic [DW-1:0] dwords [LINE_DW];
  logic [HW-1:0] words  [NWORD];

  for (genvar g = 0; g < LINE_DW; g++) begin : g_dw
    assign dwords[g] = payload[g*DW +: DW];
  end
  for (genvar g = 0; g < NWORD; g++) begin : g_w
    assign words[g] = payload[g*HW +: HW];
  end

  always_comb begin
    if (wide) begin
      beat_addr = base + (AW'(idx) << WSH);
      beat_data = dwords[idx[DIW-1:0]];
    end else begin
      beat_addr = base + (AW'(idx) << NSH);
      beat_data = {{HW{1'b0}}, words[idx]};
    end
  end
endmodule

// File: rtl/wbc_write_ctrl.sv
module wbc_write_ctrl
  import wbc_pkg::*;
#(
  parameter int AW      = 32,
  parameter int DW      = 64,
  parameter int LINE_DW = 4,
  parameter int DLY_W   = 3
) (
  input  logic                  clk,
  input  logic                  arst_n,
  input  logic [DLY_W-1:0]      mode_dly,
  input  logic                  mode_wide,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_block,
  input  logic                  req_dword,
  input  logic [AW-1:0]         req_addr,
  input  logic [DW*LINE_DW-1:0] req_data,
  output logic                  busy,
  output logic                  bus_addr_valid,
  output logic [AW-1:0]         bus_addr,
  output logic                  bus_data_valid,
  output logic [DW-1:0]         bus_data,
  input  logic                  bus_ready
);
  localparam int LINE_BITS = DW * LINE_DW;
  localparam int BEAT_MAX  = 2 * LINE_DW;
  localparam int BW        = $clog2(BEAT_MAX);
  localparam int OFF_W     = $clog2(LINE_BITS / 8);
  localparam int DOFF_W    = $clog2(DW / 8);

  logic             rst_s;
  logic [DLY_W-1:0] cfg_dly;
  logic             cfg_wide;

  wbc_state_e st_q, st_d;
  logic [AW-1:0]        base_q, base_d;
  logic [LINE_BITS-1:0] pay_q;
  logic [BW-1:0]        last_q, last_d;
  logic [BW-1:0]        idx_q, idx_d;
  logic                 acc, beat_done, gap_last;
  logic [AW-1:0]        beat_addr;
  logic [DW-1:0]        beat_data;

  wbc_rst_sync u_rst (.clk(clk), .arst_n(arst_n), .rst_n_o(rst_s));

  wbc_cfg_latch #(.DLY_W(DLY_W)) u_cfg (
    .clk(clk), .rst_n(rst_s), .mode_dly(mode_dly), .mode_wide(mode_wide),
    .cfg_dly(cfg_dly), .cfg_wide(cfg_wide)
  );

  wbc_gap_timer #(.DLY_W(DLY_W)) u_gap (
    .clk(clk), .rst_n(rst_s),
    .load(st_q == ST_ADDR), .dec(st_q == ST_GAP),
    .load_val(cfg_dly), .last(gap_last)
  );

  wbc_beat_sel #(.AW(AW), .DW(DW), .LINE_DW(LINE_DW), .BW(BW)) u_sel (
    .payload(pay_q), .base(base_q), .idx(idx_q), .wide(cfg_wide),
    .beat_addr(beat_addr), .beat_data(beat_data)
  );

  assign acc       = req_valid && (st_q == ST_IDLE);
  assign beat_done = (st_q == ST_DATA) && bus_ready;

  // Request decode: aligned base address and index of the final beat.
  always_comb begin
    if (req_block)      base_d = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};
    else if (req_dword) base_d = {req_addr[AW-1:DOFF_W], {DOFF_W{1'b0}}};
    else                base_d = req_addr;

    if (req_block)      last_d = cfg_wide ? BW'(LINE_DW - 1) : BW'(BEAT_MAX - 1);
    else if (req_dword) last_d = cfg_wide ? BW'(0) : BW'(1);
    else                last_d = BW'(0);
  end

  // Next-state logic.
  always_comb begin
    st_d  = st_q;
    idx_d = idx_q;
    unique case (st_q)
      ST_IDLE: begin
        idx_d = '0;
        if (acc) st_d = ST_ADDR;
      end
      ST_ADDR: st_d = (cfg_dly == '0) ? ST_DATA : ST_GAP;
      ST_GAP:  if (gap_last) st_d = ST_DATA;
      ST_DATA: begin
        if (beat_done) begin
          if (idx_q == last_q) st_d = ST_IDLE;
          else                 idx_d = idx_q + 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers.
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
    end else begin
      st_q  <= st_d;
      idx_q <= idx_d;
    end
  end

  // Request capture, enabled on acceptance only.
  always_ff @(posedge clk) begin
    if (acc) begin
      base_q <= base_d;
      pay_q  <= req_data;
      last_q <= last_d;
    end
  end

  assign req_ready      = (st_q == ST_IDLE);
  assign busy           = (st_q != ST_IDLE);
  assign bus_addr_valid = (st_q == ST_ADDR);
  assign bus_data_valid = (st_q == ST_DATA);
  assign bus_addr       = (st_q == ST_ADDR) ? base_q :
                          (st_q == ST_DATA) ? beat_addr : '0;
  assign bus_data       = (st_q == ST_DATA) ? beat_data : '0;
endmodule

// File: rtl/wbc_write_ctrl_chk.sv
module wbc_write_ctrl_chk #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] cfg_dly,
  input logic             cfg_wide,
  input logic             busy,
  input logic             bus_addr_valid,
  input logic             bus_data_valid,
  input logic             bus_ready,
  input logic [AW-1:0]    bus_addr,
  input logic [DW-1:0]    bus_data
);
  // R1: captured settings never move after reset release.
  a_r1_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($stable(cfg_dly) && $stable(cfg_wide)));

  // R2: the address cycle lasts a single clock.
  a_r2_one_addr: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr_valid |=> !bus_addr_valid);

  // R3: zero gap puts data right behind the address.
  a_r3_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_valid && cfg_dly == '0) |=> bus_data_valid);

  // R4: a non-zero gap keeps the next clock quiet.
  a_r4_gap_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr_valid && cfg_dly != '0) |=> (!bus_data_valid && !bus_addr_valid));

  // R8: a stalled beat holds its contents.
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data_valid && !bus_ready) |=>
      (bus_data_valid && $stable(bus_data) && $stable(bus_addr)));

  // R9: busy starts with the address cycle.
  a_r9_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bus_addr_valid);

  // R9: nothing is driven on the bus while idle.
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!bus_addr_valid && !bus_data_valid));
endmodule

bind wbc_write_ctrl wbc_write_ctrl_chk #(.AW(AW), .DW(DW), .DLY_W(DLY_W)) u_chk (
  .clk(clk), .rst_n(rst_s), .cfg_dly(cfg_dly), .cfg_wide(cfg_wide),
  .busy(busy), .bus_addr_valid(bus_addr_valid), .bus_data_valid(bus_data_valid),
  .bus_ready(bus_ready), .bus_addr(bus_addr), .bus_data(bus_data)
);

// File: tb/wbc_write_ctrl_test.sv
`timescale 1ns/1ps
module wbc_write_ctrl_test;
  logic         clk = 1'b0;
  logic         arst_n;
  logic [2:0]   mode_dly;
  logic         mode_wide;
  logic         req_valid, req_block, req_dword;
  logic         req_ready, busy;
  logic [31:0]  req_addr;
  logic [255:0] req_data;
  logic         bus_addr_valid, bus_data_valid, bus_ready;
  logic [31:0]  bus_addr;
  logic [63:0]  bus_data;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int cur_dly;
  bit cur_wide;

  always #2 clk = ~clk;

  wbc_write_ctrl uut (
    .clk(clk), .arst_n(arst_n), .mode_dly(mode_dly), .mode_wide(mode_wide),
    .req_valid(req_valid), .req_ready(req_ready), .req_block(req_block),
    .req_dword(req_dword), .req_addr(req_addr), .req_data(req_data),
    .busy(busy), .bus_addr_valid(bus_addr_valid), .bus_addr(bus_addr),
    .bus_data_valid(bus_data_valid), .bus_data(bus_data), .bus_ready(bus_ready)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_beats(bit blk, bit dw, bit wide);
    if (blk) return wide ? 4 : 8;
    if (dw && !wide) return 2;
    return 1;
  endfunction

  function automatic logic [31:0] exp_base(bit blk, bit dw, logic [31:0] a);
    if (blk) return {a[31:5], 5'b0};
    if (dw)  return {a[31:3], 3'b0};
    return a;
  endfunction

  function automatic logic [31:0] exp_baddr(logic [31:0] b, int i, bit wide);
    return b + 32'(i * (wide ? 8 : 4));
  endfunction

  function automatic logic [63:0] exp_bdata(logic [255:0] p, int i, bit wide);
    if (wide) return p[i*64 +: 64];
    return {32'b0, p[i*32 +: 32]};
  endfunction

  task automatic do_reset(input int d, input bit w);
    @(negedge clk);
    arst_n = 1'b0; mode_dly = 3'(d); mode_wide = w;
    req_valid = 1'b0; bus_ready = 1'b0;
    repeat (4) @(negedge clk);
    chk(!busy && !bus_addr_valid && !bus_data_valid && req_ready, "R10 reset state",
        {60'b0, busy, bus_addr_valid, bus_data_valid, req_ready}, 64'h1);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: scramble the mode pins after release; captured values must rule.
    mode_dly  = 3'($urandom);
    mode_wide = 1'($urandom);
    cur_dly = d; cur_wide = w;
  endtask

  task automatic do_write(input bit blk, input bit dw, input logic [31:0] a,
                          input logic [255:0] p, input int rdy_pct, input bit probe);
    int nb, beats, t;
    logic [31:0] base;
    nb = exp_beats(blk, dw, cur_wide);
    base = exp_base(blk, dw, a);
    @(negedge clk);
    req_valid = 1'b1; req_block = blk; req_dword = dw; req_addr = a; req_data = p;
    bus_ready = 1'($urandom_range(0, 1));
    @(negedge clk);
    req_valid = 1'b0;
    chk(bus_addr_valid && busy, "R2 R9 address cycle",
        {62'b0, bus_addr_valid, busy}, 64'h3);
    chk(bus_addr == base, "R2 base address", 64'(bus_addr), 64'(base));
    if (probe) begin
      req_valid = 1'b1; req_addr = ~a; req_block = ~blk;
    end
    beats = 0; t = 0;
    while (beats < nb) begin
      @(negedge clk);
      t++;
      if (t > 300) begin
        chk(1'b0, "watchdog transaction", 64'(t), 64'd300);
        break;
      end
      chk(!bus_addr_valid, "R2 single address cycle", 64'(bus_addr_valid), 64'd0);
      if (probe) chk(!req_ready, "R9 not ready while busy", 64'(req_ready), 64'd0);
      if (beats == 0 && t <= cur_dly)
        chk(!bus_data_valid, "R4 gap quiet", 64'(bus_data_valid), 64'd0);
      if (beats == 0 && t == cur_dly + 1)
        chk(bus_data_valid, cur_dly == 0 ? "R3 R1 first beat timing" : "R4 R1 first beat timing",
            64'(bus_data_valid), 64'd1);
      if (bus_data_valid) begin
        chk(bus_addr == exp_baddr(base, beats, cur_wide), "R5 R6 beat address",
            64'(bus_addr), 64'(exp_baddr(base, beats, cur_wide)));
        chk(bus_data == exp_bdata(p, beats, cur_wide), "R7 beat data",
            bus_data, exp_bdata(p, beats, cur_wide));
        bus_ready = ($urandom_range(0, 99) < rdy_pct);
        if (bus_ready) beats++;
        else chk(busy, "R8 stall keeps busy", 64'(busy), 64'd1);
      end else begin
        bus_ready = 1'($urandom_range(0, 1));
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    bus_ready = 1'b0;
    chk(!busy && req_ready && !bus_data_valid, "R5 R9 done after last beat",
        {61'b0, busy, req_ready, bus_data_valid}, 64'h2);
    if (probe) begin
      @(negedge clk);
      chk(!bus_addr_valid && !busy, "R9 busy request ignored",
          {62'b0, bus_addr_valid, busy}, 64'h0);
    end
  endtask

  function automatic logic [255:0] rnd_pay();
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = $urandom;
    return v;
  endfunction

  initial begin
    int cfg_d [6] = '{0, 0, 7, 7, 3, 5};
    bit cfg_w [6] = '{1, 0, 1, 0, 0, 1};
    void'($urandom(32'h5eed_1234));
    arst_n = 1'b0; mode_dly = 3'd0; mode_wide = 1'b1;
    req_valid = 1'b0; req_block = 1'b0; req_dword = 1'b0;
    req_addr = '0; req_data = '0; bus_ready = 1'b0;
    for (int c = 0; c < 14; c++) begin
      int d; bit w;
      d = (c < 6) ? cfg_d[c] : int'($urandom_range(0, 7));
      w = (c < 6) ? cfg_w[c] : 1'($urandom);
      do_reset(d, w);
      do_write(1'b1, 1'b0, 32'h1000_0017, rnd_pay(), 100, 1'b0);  // R5 line, unaligned
      do_write(1'b0, 1'b1, 32'h2000_000D, rnd_pay(), 40,  1'b0);  // R6 doubleword
      do_write(1'b0, 1'b0, 32'h3000_0006, rnd_pay(), 100, 1'b0);  // R6 small single
      do_write(1'b1, 1'b0, 32'h4000_0040, rnd_pay(), 30,  1'b1);  // R8 R9 stall + probe
      for (int k = 0; k < 8; k++)
        do_write(1'($urandom), 1'($urandom), $urandom, rnd_pay(),
                 int'($urandom_range(20, 100)), 1'($urandom));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule